// File: doc/BRIEF.md
# Serial-Bus Seconds Counter with Scratch SRAM

A slave on a four-wire serial bus (active-low select, serial clock, data in, data out) that keeps a free-running 32-bit seconds count, sixteen 32-bit words of scratch storage, and eight auxiliary 32-bit registers. The auxiliary registers are two timer words, four test words and two control words, all kept as plain storage. The seconds count advances from a prescaler on the system clock. One of the scratch words is reserved by convention for a bias that software adds to the count. The block only stores that word.

Each frame is 64 serial clocks long, framed by select held low. The first 32 bits are a command word. Its bit 31 picks the direction and its lower bits hold a register address. The next 32 bits are the data word. On a write, the host shifts the data word in. On a read, the block shifts it out. Words travel most-significant bit first. The block samples the data input on each rising serial clock, and it advances the data output just after that same edge. The serial inputs are assumed to be synchronous to the system clock and several system clocks slower.

Top module: `serial_rtc_sram`

## Requirements
- R1: A frame is a 32-bit command word followed by a 32-bit data word, both most-significant bit first, sampled on rising serial clock edges while cs_ni is low. Command bit 31 = 1 means write and 0 means read. The address is bits 30:0.
- R2: Address 0x20000000 is the seconds count. A read returns it, and a write loads it with the data word.
- R3: The count increments by one every TICKS_PER_SEC system clocks. After a load, the next increment comes TICKS_PER_SEC clocks after the load edge, counting up from the loaded value.
- R4: Scratch word i (i = 0..15) sits at 0x20000100 + i*0x100. Each word reads back its last written value independently. Word 3 (0x20000400, the bias) is plain storage and leaves the count untouched.
- R5: The on-timer (0x21000000), off-timer (0x21000100), test words (0x21000400, 0x21000500, 0x21000600, 0x21000700) and control words (0x21000C00, 0x21000D00) each read back their last written value.
- R6: A read of 0x20400000 returns the count as it stands at the edge where the command's last bit is taken. A write there has no effect.
- R7: A read of any other address returns zero, and a write to one changes no register.
- R8: Raising cs_ni before the 64th bit abandons the frame: no write occurs, and the next frame starts with a fresh command word.
- R9: miso_o is 0 while cs_ni is high and throughout the command phase. On a read, the data word's bit 31 is on miso_o before the first data-phase rising edge.
- R10: After reset the count, all scratch words and all auxiliary registers are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, also drives the prescaler |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Frame select, active low |
| sck_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |

## Verification
The bench predicts every count read from the cycle of the last load and the cycle of the command decode. A prescaler that is off by one, or that does not restart on a load, therefore shows up as a wrong count or a wrong snapshot. It writes to addresses that would alias a real register if the index were truncated or the low byte ignored, such as one step past the last scratch word and the gap between the timers. A loose decoder would then corrupt scratch word 0 or a neighbouring timer. It cuts frames short in both the command phase and the data phase. A design that does not clear its bit count on deselect would either commit the partial write or misframe the next command. Asymmetric data patterns expose a reversed bit order, and a miso that is loaded one edge late loses the data word's top bit.

// File: rtl/serial_rtc_pkg.sv
package serial_rtc_pkg;
  localparam int WORD_W     = 32;
  localparam int SRAM_WORDS = 16;
  localparam int AUX_REGS   = 8;
  localparam int IDX_W      = 4;

  localparam logic [30:0] CNT_ADDR  = 31'h2000_0000;
  localparam logic [30:0] SNAP_ADDR = 31'h2040_0000;
  localparam logic [30:0] SRAM_BASE = 31'h2000_0100;

  localparam logic [30:0] AUX_ADDR [AUX_REGS] = '{
    31'h2100_0000, 31'h2100_0100, 31'h2100_0400, 31'h2100_0500,
    31'h2100_0600, 31'h2100_0700, 31'h2100_0C00, 31'h2100_0D00
  };

  typedef enum logic [2:0] {
    TGT_NONE, TGT_COUNT, TGT_SNAP, TGT_SRAM, TGT_AUX
  } tgt_kind_e;

  typedef struct packed {
    tgt_kind_e        kind;
    logic [IDX_W-1:0] idx;
  } tgt_t;

  function automatic tgt_t decode_addr(logic [30:0] a);
    tgt_t        t;
    logic [30:0] off;
    t.kind = TGT_NONE;
    t.idx  = '0;
    off    = a - SRAM_BASE;
    if (a == CNT_ADDR) begin
      t.kind = TGT_COUNT;
    end else if (a == SNAP_ADDR) begin
      t.kind = TGT_SNAP;
    end else if (off[7:0] == 8'd0 && off[30:8] < 23'(SRAM_WORDS)) begin
      t.kind = TGT_SRAM;
      t.idx  = off[8 +: IDX_W];
    end else begin
      for (int i = 0; i < AUX_REGS; i++) begin
        if (a == AUX_ADDR[i]) begin
          t.kind = TGT_AUX;
          t.idx  = IDX_W'(i);
        end
      end
    end
    return t;
  endfunction
endpackage

// File: rtl/rtc_serial_port.sv
module rtc_serial_port #(
  parameter int W = 32,
  localparam int CW = $clog2(2 * W) + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         sck_i,
  input  logic         mosi_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  output logic         miso_o,
  output logic         cmd_stb_o,
  output logic         data_stb_o,
  output logic [W-1:0] word_o
);
  logic          sck_q;
  logic [CW-1:0] bit_q;
  logic [W-1:0]  in_q, out_q;
  logic          active, rise;

  // bit_q reaches 2*W once a frame is complete; further edges are ignored
  assign active     = ~cs_ni && (bit_q < CW'(2 * W));
  assign rise       = sck_i & ~sck_q & active;
  assign word_o     = {in_q[W-2:0], mosi_i};
  assign cmd_stb_o  = rise && (bit_q == CW'(W - 1));
  assign data_stb_o = rise && (bit_q == CW'(2 * W - 1));
  assign miso_o     = ~cs_ni & out_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      bit_q <= '0;
      in_q  <= '0;
      out_q <= '0;
    end else begin
      sck_q <= sck_i;
      if (cs_ni) begin
        bit_q <= '0;
        out_q <= '0;
      end else if (rise) begin
        bit_q <= bit_q + CW'(1);
        in_q  <= word_o;
        if (ld_i)                   out_q <= ld_data_i;
        else if (bit_q >= CW'(W))   out_q <= {out_q[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int TICKS_PER_SEC = 100_000_000,
  parameter int W = 32,
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] count_o
);
  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      count_o <= '0;
    end else if (ld_i) begin
      pre_q   <= '0;
      count_o <= ld_val_i;
    end else if (pre_q == PW'(TICKS_PER_SEC - 1)) begin
      pre_q   <= '0;
      count_o <= count_o + W'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end
endmodule

// File: rtl/rtc_word_store.sv
module rtc_word_store #(
  parameter int DEPTH = 16,
  parameter int W = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [W-1:0]  rd_o
);
  logic [W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mem[g] <= '0;
      else if (we_i && wa_i == AW'(g))    mem[g] <= wd_i;
    end
  end

  assign rd_o = mem[ra_i];
endmodule

// File: rtl/serial_rtc_sram.sv
module serial_rtc_sram
  import serial_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o
);
  localparam int SRAM_AW = $clog2(SRAM_WORDS);
  localparam int AUX_AW  = $clog2(AUX_REGS);

  logic              cmd_stb, data_stb;
  logic [WORD_W-1:0] word, count, rd_data, sram_rd, aux_rd;
  tgt_t              cur, tgt_q;
  logic              wr_q, rd_ld, wr_go, cnt_ld, sram_we, aux_we;

  assign cur = decode_addr(word[30:0]);

  always_comb begin
    unique case (cur.kind)
      TGT_COUNT, TGT_SNAP: rd_data = count;
      TGT_SRAM:            rd_data = sram_rd;
      TGT_AUX:             rd_data = aux_rd;
      default:             rd_data = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      tgt_q <= '{kind: TGT_NONE, idx: '0};
    end else if (cmd_stb) begin
      wr_q  <= word[31];
      tgt_q <= cur;
    end
  end

  assign rd_ld   = cmd_stb & ~word[31];
  assign wr_go   = data_stb & wr_q;
  assign cnt_ld  = wr_go && (tgt_q.kind == TGT_COUNT);
  assign sram_we = wr_go && (tgt_q.kind == TGT_SRAM);
  assign aux_we  = wr_go && (tgt_q.kind == TGT_AUX);

  rtc_serial_port #(.W(WORD_W)) u_port (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .mosi_i,
    .ld_i       (rd_ld),
    .ld_data_i  (rd_data),
    .miso_o,
    .cmd_stb_o  (cmd_stb),
    .data_stb_o (data_stb),
    .word_o     (word)
  );

  rtc_sec_counter #(.TICKS_PER_SEC(TICKS_PER_SEC), .W(WORD_W)) u_cnt (
    .clk_i, .rst_ni,
    .ld_i     (cnt_ld),
    .ld_val_i (word),
    .count_o  (count)
  );

  rtc_word_store #(.DEPTH(SRAM_WORDS), .W(WORD_W)) u_sram (
    .clk_i, .rst_ni,
    .we_i (sram_we),
    .wa_i (tgt_q.idx[SRAM_AW-1:0]),
    .wd_i (word),
    .ra_i (cur.idx[SRAM_AW-1:0]),
    .rd_o (sram_rd)
  );

  rtc_word_store #(.DEPTH(AUX_REGS), .W(WORD_W)) u_aux (
    .clk_i, .rst_ni,
    .we_i (aux_we),
    .wa_i (tgt_q.idx[AUX_AW-1:0]),
    .wd_i (word),
    .ra_i (cur.idx[AUX_AW-1:0]),
    .rd_o (aux_rd)
  );
endmodule

// File: rtl/serial_rtc_sram_checker.sv
module serial_rtc_sram_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_ni,
  input logic        miso_o,
  input logic        cmd_stb,
  input logic        data_stb,
  input logic [31:0] word,
  input logic        cnt_ld,
  input logic [31:0] count,
  input logic [31:0] rd_data
);
  logic seen_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_cmd <= 1'b0;
    else if (cs_ni)   seen_cmd <= 1'b0;
    else if (cmd_stb) seen_cmd <= 1'b1;
  end

  // R1: data word only after a command word in the same frame
  a_r1_data_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_stb |-> seen_cmd);

  a_r1_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_stb && data_stb));

  a_r2_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ld |=> count == $past(word));

  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_ld |=> (count == $past(count)) || (count == $past(count) + 32'd1));

  a_r8_no_strobe_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !cmd_stb && !data_stb);

  a_r9_first_bit_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb && !word[31]) |=> cs_ni || (miso_o == $past(rd_data[31])));
endmodule

bind serial_rtc_sram serial_rtc_sram_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .miso_o   (miso_o),
  .cmd_stb  (cmd_stb),
  .data_stb (data_stb),
  .word     (word),
  .cnt_ld   (cnt_ld),
  .count    (count),
  .rd_data  (rd_data)
);

// File: tb/serial_rtc_sram_bench.sv
module serial_rtc_sram_bench;
  localparam int TICKS = 40;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  always #2 clk = ~clk;

  serial_rtc_sram #(.TICKS_PER_SEC(TICKS)) u_serial_rtc_sram (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n),
    .sck_i(sck), .mosi_i(mosi), .miso_o(miso)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  int unsigned base_t;
  logic [31:0] base_v;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: rebuilds each frame from the wires and compares read data
  int          mon_n = 0;
  logic [31:0] mon_cmd = '0;
  logic [31:0] mon_rd = '0;
  logic        mon_cmd_miso = 1'b0;

  always @(posedge sck) begin
    if (!cs_n) begin
      if (mon_n < 32) begin
        mon_cmd = {mon_cmd[30:0], mosi};
        mon_cmd_miso = mon_cmd_miso | miso;
      end else if (mon_n < 64) begin
        mon_rd = {mon_rd[30:0], miso};
      end
      mon_n++;
    end
  end

  always @(posedge cs_n) begin
    if (mon_n == 64 && !mon_cmd[31]) begin
      if (sb_q.size() == 0) begin
        chk("R1 (no expected item)", mon_rd, 32'hxxxx_xxxx);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, mon_rd, it.exp);
        chk("R9 miso low in command phase", {31'd0, mon_cmd_miso}, 32'd0);
      end
    end
    mon_n = 0;
    mon_cmd_miso = 1'b0;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] w, int nbits, output int unsigned t_last);
    for (int i = 31; i > 31 - nbits; i--) begin
      mosi = w[i];
      tick(HALF);
      sck = 1'b1;
      t_last = cyc + 1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    tick(2);
  endtask

  task automatic close_frame();
    tick(2);
    cs_n = 1'b1;
    tick(4);
  endtask

  task automatic wr(logic [31:0] addr, logic [31:0] data, output int unsigned t_ld);
    int unsigned t;
    open_frame();
    send_bits(addr | 32'h8000_0000, 32, t);
    send_bits(data, 32, t_ld);
    close_frame();
  endtask

  task automatic wr_cnt(logic [31:0] data);
    int unsigned t;
    wr(32'h2000_0000, data, t);
    base_t = t;
    base_v = data;
  endtask

  task automatic rd(logic [31:0] addr, logic [31:0] exp, string tag);
    int unsigned t;
    item_t it;
    open_frame();
    send_bits(addr & 32'h7FFF_FFFF, 32, t);
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    send_bits(32'h0, 32, t);
    close_frame();
  endtask

  // Count reads: expected value from the decode edge and the last load edge
  task automatic rd_cnt(logic [31:0] addr, string tag);
    int unsigned td, t;
    item_t it;
    open_frame();
    send_bits(addr & 32'h7FFF_FFFF, 32, td);
    it.exp = base_v + 32'((td - 1 - base_t) / TICKS);
    it.tag = tag;
    sb_q.push_back(it);
    send_bits(32'h0, 32, t);
    close_frame();
  endtask

  logic [31:0] aux_a [8] = '{32'h2100_0000, 32'h2100_0100, 32'h2100_0400, 32'h2100_0500,
                             32'h2100_0600, 32'h2100_0700, 32'h2100_0C00, 32'h2100_0D00};

  initial begin
    int unsigned t;
    tick(5);
    rst_n = 1'b1;
    base_t = cyc;
    base_v = 32'd0;
    tick(2);
    chk("R9 miso low while deselected", {31'd0, miso}, 32'd0);

    // R10 reset state
    rd_cnt(32'h2000_0000, "R10 count from zero after reset");
    rd(32'h2000_0600, 32'd0, "R10 scratch word 5 zero");
    rd(32'h2100_0D00, 32'd0, "R10 control1 zero");

    // R2 / R3 load and count
    wr_cnt(32'h1234_5678);
    rd_cnt(32'h2000_0000, "R2 count after load");
    tick(300);
    rd_cnt(32'h2000_0000, "R3 count advances from loaded value");
    wr_cnt(32'hFFFF_FFFE);
    tick(100);
    rd_cnt(32'h2000_0000, "R3 count wraps");

    // R4 scratch words, R1 bit order via asymmetric patterns
    for (int i = 0; i < 16; i++)
      wr(32'h2000_0100 + 32'(i) * 32'h100, 32'h8000_0001 ^ (32'(i) * 32'h0101_0110), t);
    for (int i = 0; i < 16; i++)
      rd(32'h2000_0100 + 32'(i) * 32'h100, 32'h8000_0001 ^ (32'(i) * 32'h0101_0110),
         "R4 R1 scratch readback");
    wr(32'h2000_0400, 32'hFFFF_FFF0, t);
    rd(32'h2000_0400, 32'hFFFF_FFF0, "R4 bias word stored");
    rd_cnt(32'h2000_0000, "R4 bias write leaves count");

    // R5 auxiliary registers
    for (int i = 0; i < 8; i++) wr(aux_a[i], 32'hC3A5_0000 | 32'(i * 7 + 1), t);
    for (int i = 0; i < 8; i++) rd(aux_a[i], 32'hC3A5_0000 | 32'(i * 7 + 1), "R5 aux readback");

    // R6 snapshot
    tick(57);
    rd_cnt(32'h2040_0000, "R6 snapshot at decode");
    wr(32'h2040_0000, 32'h0BAD_0BAD, t);
    rd_cnt(32'h2000_0000, "R6 snapshot write ignored");

    // R7 undecoded addresses
    rd(32'h3000_0000, 32'd0, "R7 undecoded read zero");
    rd(32'h2000_0180, 32'd0, "R7 unaligned read zero");
    wr(32'h2000_1100, 32'hDEAD_BEEF, t);
    rd(32'h2000_0100, 32'h8000_0001, "R7 write past last word ignored");
    rd(32'h2000_1100, 32'd0, "R7 past last word reads zero");
    wr(32'h2100_0200, 32'hDEAD_BEEF, t);
    rd(32'h2100_0100, 32'hC3A5_0008, "R7 timer gap write ignored");
    rd(32'h2100_0400, 32'hC3A5_000F, "R7 test0 untouched");
    wr(32'h2000_0080, 32'h0000_0005, t);
    rd_cnt(32'h2000_0000, "R7 near-count write ignored");

    // R8 aborted frames
    open_frame();
    send_bits(32'hA000_0300, 32, t);
    send_bits(32'h5555_5555, 8, t);
    close_frame();
    rd(32'h2000_0300, 32'h8000_0001 ^ 32'h0202_0220, "R8 data-phase abort no write");
    open_frame();
    send_bits(32'h2000_0500, 10, t);
    close_frame();
    rd(32'h2000_0500, 32'h8000_0001 ^ 32'h0404_0440, "R8 command-phase abort reframes");
    open_frame();
    send_bits(32'hA000_0000, 20, t);
    close_frame();
    rd_cnt(32'h2000_0000, "R8 aborted count write");

    tick(10);
    if (sb_q.size() != 0) chk("R1 pending reads", 32'(sb_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule